// File: doc/BRIEF.md
# Sampled Multi-Size Miss Profiler

This block is a shadow tag directory that sits beside a shared last-level cache. It never holds data, and it never slows the cache. It watches the stream of cache accesses, each tagged with the core that made it. For every core, it estimates the miss count that core would see in seven caches of different sizes: the real size, and that size halved one to six times. The counts give a power manager the miss-versus-capacity curve it needs to decide how much cache each core should keep powered.

Accesses enter a small queue, so the profiler adds no back-pressure. When the queue is full, an access is dropped and a sticky flag is raised. A controller takes one access at a time from the queue. A filter keeps only the accesses that fall into sampled sets. The controller then looks up the emulated sizes in turn, one per cycle, each with its own tag store and LRU state. Every emulated size of every core has its own miss counter.

A one-cycle interval-end pulse captures all counters into a snapshot register and clears the live counters. The same pulse invalidates every stored tag and discards queued or in-flight accesses, so each interval is profiled from a cold state.

Top module: `miss_profiler`

## Requirements
- R1: Emulated size k (k = 0..6) holds (SETS/RATIO)>>k sets per core. The line key is address bits above the line offset and sampling bits. The set is selected by the low log2((SETS/RATIO)>>k) bits of that key, and the whole key is compared as the tag.
- R2: An access whose sampling bits (the log2(RATIO) address bits just above the line offset) are not all zero changes no counter.
- R3: Each core's accesses use only that core's tag stores and counters. Another core's counters are left unchanged.
- R4: In each emulated size, a lookup that misses adds one to that core's counter for that size and fills the least recently used way. A hit makes the way most recently used. Replacement is true LRU over WAYS ways.
- R5: After a one-cycle interval_end pulse, snap_valid is 1 in the following cycle only. At that point the snapshot shows the counts accumulated before the pulse. Live counters are zeroed and all tags invalidated, so an address seen before the pulse misses again afterwards.
- R6: The block has no ready output. An access arriving while the queue holds QDEPTH entries is dropped, and overflow is set to 1 and stays 1 until reset.
- R7: After reset, snap_valid and overflow are 0 and every snapshot counter is 0.
- R8: Counter for core c and size k sits at snap_counts[(c*7+k)*CNT_W +: CNT_W]. It is an unsigned binary count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| acc_core | input | $clog2(CORES) | Requesting core |
| interval_end | input | 1 | Capture counters, then clear counters and tags |
| snap_valid | output | 1 | Snapshot updated last cycle |
| snap_counts | output | CORES*7*CNT_W | Captured miss counters |
| overflow | output | 1 | Sticky: an access was dropped |

## Verification
Directed patterns separate the behaviours:
- A run of WAYS+1 keys in one set, followed by the first key again, shows whether the LRU victim is chosen correctly.
- A working set that fits the full-size sets but collides once the set count halves shows whether the index shrinks correctly at each size.
- A stream of only unsampled addresses, and a stream from only one core, show whether the filter and the per-core separation work.
- Repeating a key just after an interval end shows whether the tags were invalidated.

Seeded random traffic mixes both cores, sampled and unsampled addresses, and a small key pool, so hits and misses interleave. Every per-size count is compared with a bench model that keeps a most-recently-used list for each set. A back-to-back burst is the one pattern that overfills the queue, and it checks that accesses are dropped and that the flag stays set.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int NUM_SIZES = 7;

    typedef enum logic {
        ST_IDLE,
        ST_LOOK
    } prof_state_e;

    // flat counter slot for a core and an emulated size
    function automatic int slot_of(input int core, input int size);
        return core * NUM_SIZES + size;
    endfunction

endpackage

// File: rtl/msp_queue.sv
module msp_queue #(
    parameter int W     = 41,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rp_q];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wp_q] <= din;
                wp_q      <= nxt(wp_q);
            end
            if (do_pop) rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)); // R6
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop && !flush |=> cnt_q == $past(cnt_q)); // R6
endmodule

// File: rtl/msp_unit.sv
module msp_unit #(
    parameter int KEY_W = 28,
    parameter int LOGN  = 6,
    parameter int WAYS  = 8,
    parameter int CORES = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clr,
    input  logic                                   en,
    input  logic [((CORES > 1) ? $clog2(CORES) : 1)-1:0] core,
    input  logic [KEY_W-1:0]                       key,
    output logic                                   hit
);
    localparam int CW    = (CORES > 1) ? $clog2(CORES) : 1;
    localparam int NSETS = 1 << LOGN;
    localparam int ENT   = CORES * NSETS;
    localparam int EW    = (ENT > 1) ? $clog2(ENT) : 1;
    localparam int IW    = (LOGN > 0) ? LOGN : 1;
    localparam int AW    = $clog2(WAYS);

    logic [KEY_W-1:0] tag_q [ENT][WAYS];
    logic [AW-1:0]    age_q [ENT][WAYS];
    logic [WAYS-1:0]  vld_q [ENT];

    logic [IW-1:0]   idx;
    logic [EW-1:0]   ent;
    logic [WAYS-1:0] hit_vec, oldest_vec;
    logic [AW-1:0]   hit_way, vic_way, tgt_way, ref_age;

    // address mapper: this size keeps only the low LOGN key bits as set index
    assign idx = IW'(key & KEY_W'(NSETS - 1));
    assign ent = EW'(core) * EW'(NSETS) + EW'(idx);

    always_comb begin
        hit_vec    = '0;
        oldest_vec = '0;
        hit_way    = '0;
        vic_way    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[ent][w] && tag_q[ent][w] == key) begin
                hit_vec[w] = 1'b1;
                hit_way    = AW'(w);
            end
            if (age_q[ent][w] == AW'(WAYS - 1)) begin
                oldest_vec[w] = 1'b1;
                vic_way       = AW'(w);
            end
        end
    end

    assign hit     = |hit_vec;
    assign tgt_way = hit ? hit_way : vic_way;
    assign ref_age = age_q[ent][tgt_way];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int e = 0; e < ENT; e++) begin
                vld_q[e] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[e][w] <= AW'(w);
            end
        end else if (en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (AW'(w) == tgt_way) begin
                    age_q[ent][w] <= '0;
                    if (!hit) begin
                        tag_q[ent][w] <= key;
                        vld_q[ent][w] <= 1'b1;
                    end
                end else if (age_q[ent][w] < ref_age) begin
                    age_q[ent][w] <= age_q[ent][w] + 1'b1;
                end
            end
        end
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        en |-> $onehot0(hit_vec)); // R4
    AST_ONE_LRU_WAY: assert property (@(posedge clk) disable iff (rst)
        en |-> $countones(oldest_vec) == 1); // R4
endmodule

// File: rtl/miss_profiler.sv
module miss_profiler
    import msp_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int LINE_W = 6,
    parameter int SETS   = 4096,
    parameter int RATIO  = 64,
    parameter int WAYS   = 8,
    parameter int CORES  = 2,
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          acc_valid,
    input  logic [ADDR_W-1:0]                             acc_addr,
    input  logic [((CORES > 1) ? $clog2(CORES) : 1)-1:0]  acc_core,
    input  logic                                          interval_end,
    output logic                                          snap_valid,
    output logic [CORES*NUM_SIZES*CNT_W-1:0]              snap_counts,
    output logic                                          overflow
);
    localparam int CW     = (CORES > 1) ? $clog2(CORES) : 1;
    localparam int SET_W  = $clog2(SETS);
    localparam int SMP_W  = $clog2(RATIO);
    localparam int SIDX_W = SET_W - SMP_W;
    localparam int KEY_W  = ADDR_W - LINE_W - SMP_W;
    localparam int QW     = CW + ADDR_W;
    localparam int SLOTS  = CORES * NUM_SIZES;

    prof_state_e       st_q;
    logic [2:0]        sz_q;
    logic [KEY_W-1:0]  cur_key_q;
    logic [CW-1:0]     cur_core_q;
    logic [QW-1:0]     q_out;
    logic              q_empty, q_full, q_pop;
    logic [ADDR_W-1:0] pop_addr;
    logic [CW-1:0]     pop_core;
    logic              pop_sampled;
    logic [NUM_SIZES-1:0] hit_all;
    logic [CNT_W-1:0]  cnt_q [SLOTS];
    logic              ovf_q, snap_v_q;
    logic [CORES*NUM_SIZES*CNT_W-1:0] snap_q;
    logic              unused_line_bits;

    msp_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .flush (interval_end),
        .push  (acc_valid),
        .din   ({acc_core, acc_addr}),
        .pop   (q_pop),
        .dout  (q_out),
        .empty (q_empty),
        .full  (q_full)
    );

    assign q_pop       = (st_q == ST_IDLE) && !q_empty && !interval_end;
    assign pop_addr    = q_out[ADDR_W-1:0];
    assign pop_core    = q_out[QW-1:ADDR_W];
    // sampling filter: only sets whose low index bits are zero are profiled
    assign pop_sampled = (pop_addr[LINE_W+SMP_W-1:LINE_W] == '0);
    assign unused_line_bits = ^pop_addr[LINE_W-1:0];

    // controller: one pop, then one emulated size per cycle
    always_ff @(posedge clk) begin
        if (rst || interval_end) begin
            st_q <= ST_IDLE;
            sz_q <= '0;
        end else if (st_q == ST_IDLE) begin
            if (q_pop && pop_sampled) begin
                st_q       <= ST_LOOK;
                sz_q       <= '0;
                cur_key_q  <= pop_addr[ADDR_W-1:LINE_W+SMP_W];
                cur_core_q <= pop_core;
            end
        end else begin
            sz_q <= sz_q + 3'd1;
            if (sz_q == 3'(NUM_SIZES - 1)) st_q <= ST_IDLE;
        end
    end

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        msp_unit #(
            .KEY_W (KEY_W),
            .LOGN  ((SIDX_W > k) ? SIDX_W - k : 0),
            .WAYS  (WAYS),
            .CORES (CORES)
        ) u_unit (
            .clk  (clk),
            .rst  (rst),
            .clr  (interval_end),
            .en   ((st_q == ST_LOOK) && (sz_q == 3'(k)) && !interval_end),
            .core (cur_core_q),
            .key  (cur_key_q),
            .hit  (hit_all[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || interval_end) begin
            for (int i = 0; i < SLOTS; i++) cnt_q[i] <= '0;
        end else if (st_q == ST_LOOK && !hit_all[sz_q]) begin
            cnt_q[slot_of(int'(cur_core_q), int'(sz_q))] <=
                cnt_q[slot_of(int'(cur_core_q), int'(sz_q))] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= '0;
            snap_v_q <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            snap_v_q <= interval_end;
            if (interval_end)
                for (int i = 0; i < SLOTS; i++) snap_q[i*CNT_W +: CNT_W] <= cnt_q[i];
            if (acc_valid && q_full) ovf_q <= 1'b1;
        end
    end

    assign snap_valid  = snap_v_q;
    assign snap_counts = snap_q;
    assign overflow    = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R6
    AST_SNAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        interval_end |=> snap_valid); // R5
    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        interval_end |=> cnt_q[0] == '0); // R5
    AST_SIZE_WALK: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_LOOK && sz_q != 3'(NUM_SIZES - 1) && !interval_end
        |=> st_q == ST_LOOK && sz_q == $past(sz_q) + 3'd1); // R1
    AST_UNSAMPLED_SKIP: assert property (@(posedge clk) disable iff (rst)
        q_pop && !pop_sampled |=> st_q == ST_IDLE); // R2
endmodule

// File: tb/sim_miss_profiler.sv
`timescale 1ns/1ps
module sim_miss_profiler;
    localparam int AW = 32, LW = 6, SETS = 512, RATIO = 16, WAYS = 4, CORES = 2;
    localparam int NS = 7, MS = 32, KW = 22, CNT_W = 32;

    logic clk = 0, rst = 1, acc_valid = 0, interval_end = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [0:0] acc_core = '0;
    logic snap_valid, overflow;
    logic [CORES*NS*CNT_W-1:0] snap_counts;

    int checks = 0, errors = 0;
    logic [KW-1:0] mk [CORES*NS*MS*WAYS];
    int mn [CORES*NS*MS];
    int expc [CORES*NS];

    always #2 clk = ~clk;

    miss_profiler #(.ADDR_W(AW), .LINE_W(LW), .SETS(SETS), .RATIO(RATIO),
                    .WAYS(WAYS), .CORES(CORES), .QDEPTH(4), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_core(acc_core), .interval_end(interval_end), .snap_valid(snap_valid),
        .snap_counts(snap_counts), .overflow(overflow));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk_addr(input int tag, input int sidx, input int smp);
        return {15'(tag), 5'(sidx), 4'(smp), 6'($urandom % 64)};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < CORES*NS*MS; i++) mn[i] = 0;
        for (int i = 0; i < CORES*NS; i++) expc[i] = 0;
    endtask

    // true LRU per set kept as an MRU-first list
    task automatic model_access(input int c, input logic [AW-1:0] a);
        logic [KW-1:0] key;
        int base, pos, n;
        if (a[9:6] != 0) return;
        key = a[31:10];
        for (int s = 0; s < NS; s++) begin
            base = (c*NS + s)*MS + int'(key % (MS >> s));
            pos = -1;
            for (int i = 0; i < mn[base]; i++) if (mk[base*WAYS+i] == key) pos = i;
            if (pos < 0) begin
                expc[c*NS+s]++;
                n = (mn[base] < WAYS) ? mn[base] + 1 : WAYS;
                pos = n - 1;
                mn[base] = n;
            end
            for (int i = pos; i > 0; i--) mk[base*WAYS+i] = mk[base*WAYS+i-1];
            mk[base*WAYS] = key;
        end
    endtask

    task automatic send(input int c, input logic [AW-1:0] a);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_core = 1'(c);
        model_access(c, a);
        @(negedge clk);
        acc_valid = 0;
        repeat (11) @(negedge clk);
    endtask

    task automatic end_interval(input string rq, input bit compare);
        @(negedge clk); interval_end = 1;
        @(negedge clk); interval_end = 0;
        chk({rq, " R5 snap_valid pulse"}, 32'(snap_valid), 1);
        if (compare)
            for (int i = 0; i < CORES*NS; i++)
                chk($sformatf("%s R8 slot %0d", rq, i), snap_counts[i*CNT_W +: CNT_W], expc[i]);
        @(negedge clk);
        chk({rq, " R5 snap_valid one cycle"}, 32'(snap_valid), 0);
        model_clear();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R7 reset state
        chk("R7 snap_valid", 32'(snap_valid), 0);
        chk("R7 overflow", 32'(overflow), 0);
        chk("R7 counters zero", 32'(snap_counts == '0), 1);

        // R4: WAYS+1 keys in one set, then the first again is an LRU miss
        for (int t = 0; t <= WAYS; t++) send(0, mk_addr(t, 0, 0));
        send(0, mk_addr(0, 0, 0));
        end_interval("R4 evict", 1);
        chk("R4 evicted key misses", snap_counts[0 +: CNT_W], WAYS + 2);
        // R4: refresh keeps key resident
        for (int t = 0; t < WAYS; t++) send(0, mk_addr(t, 1, 0));
        send(0, mk_addr(0, 1, 0));
        send(0, mk_addr(9, 1, 0));
        send(0, mk_addr(0, 1, 0));
        end_interval("R4 refresh", 1);
        chk("R4 refreshed key hits", snap_counts[0 +: CNT_W], WAYS + 1);

        // R1: fits full size, collides when sets halve
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < 3; t++) begin
                send(0, mk_addr(t, 0, 0));
                send(0, mk_addr(t, 16, 0));
            end
        end_interval("R1 halving", 1);
        chk("R1 full size misses", snap_counts[0 +: CNT_W], 6);
        chk("R1 half size misses", snap_counts[CNT_W +: CNT_W], 12);

        // R5: tags invalidated, same key misses again
        send(0, mk_addr(0, 0, 0));
        end_interval("R5 cold", 1);
        chk("R5 cold miss smallest size", snap_counts[6*CNT_W +: CNT_W], 1);

        // R2: unsampled accesses only
        for (int i = 0; i < 10; i++) send(1, mk_addr(i, i, 1 + (i % 15)));
        end_interval("R2 unsampled", 1);
        chk("R2 nothing counted", 32'(snap_counts == '0), 1);

        // R3: core 1 only
        for (int i = 0; i < 12; i++) send(1, mk_addr(i % 5, i % 3, 0));
        end_interval("R3 one core", 1);
        chk("R3 core0 untouched", 32'(snap_counts[0 +: NS*CNT_W] == '0), 1);

        // R4 R8 random mix
        for (int iv = 0; iv < 3; iv++) begin
            for (int i = 0; i < 60; i++) begin
                int c, smp;
                c = $urandom % 2;
                smp = (($urandom % 4) != 0) ? 0 : 1 + ($urandom % 15);
                send(c, mk_addr($urandom % 4, $urandom % 8, smp));
            end
            end_interval($sformatf("R4 random %0d", iv), 1);
        end

        // R6 burst overfills the queue
        chk("R6 no overflow yet", 32'(overflow), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            acc_valid = 1; acc_addr = mk_addr(i, i % 8, 0); acc_core = 1'b0;
        end
        @(negedge clk); acc_valid = 0;
        repeat (200) @(negedge clk);
        chk("R6 overflow set", 32'(overflow), 1);
        end_interval("R6 burst", 0);
        chk("R6 some dropped", 32'(snap_counts[0 +: CNT_W] < 20), 1);
        chk("R6 some kept", 32'(snap_counts[0 +: CNT_W] > 0), 1);
        send(0, mk_addr(1, 1, 0));
        end_interval("R6 after", 1);
        chk("R6 overflow sticky", 32'(overflow), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule